// File: doc/BRIEF.md
# Star Coupler Interlink Port

This block runs one end of a two-wire, open-drain interlink between two neighbouring star couplers, so the couplers can share bus state. Only one direction is used at a time, chosen by a direction input. When the port sends, the local bus state (low symbol, high symbol or idle) is mapped onto the two active-low wires. Each wire is either pulled low or released to its pull-up.

When the port receives, the two wire levels pass through a synchronizer. The port then decodes them into a bus state that the coupler can forward onto its branches. It also emits a one-cycle activity pulse for every falling edge, and a one-cycle collision pulse when both wires go low at the same time. The port sends and decodes only in the normal operating mode. In every low-power or reset mode it leaves both wires released and reports idle.

Top module: `ilink_port`

## Requirements
- R1: Bus states are coded as 0 = idle, 1 = low symbol, 2 = high symbol. In send direction (`drive_dir_i` = 1) with operating mode 0 (normal), bus state 1 sets `link_pull_o` to 2'b01, which pulls wire 0 (bit 0) low and releases wire 1. The output is registered and follows its inputs after one clock.
- R2: In send direction and normal mode, bus state 2 sets `link_pull_o` to 2'b10, which pulls wire 1 (bit 1) low and releases wire 0.
- R3: In send direction and normal mode, bus state 0 and the unused code 3 both leave `link_pull_o` at 2'b00.
- R4: Operating modes 1 (standby), 2 (sleep), 3 (power-off), 4 (reset) and every other non-zero code leave both wires released for any bus state. Both wires are also released in receive direction (`drive_dir_i` = 0).
- R5: Each wire level in `link_lvl_i` (bit 0 = wire 0, 1 = high) passes through `SYNC_STAGES` flops before the edge detector. A level change first shows on the receive outputs `SYNC_STAGES`+1 clocks after it is applied, which is 3 with the defaults.
- R6: In receive direction and normal mode, a falling edge on wire 0 sets `rx_state_o` to 1 (low symbol), and a falling edge on wire 1 sets it to 2 (high symbol). With exactly one wire low and no new edge, `rx_state_o` keeps its previous value.
- R7: In receive direction and normal mode, both wires high decode to `rx_state_o` = 0 (idle).
- R8: In receive direction and normal mode, both wires low force `rx_state_o` to 1. `collision_o` pulses high for exactly one clock when the both-low condition begins.
- R9: In receive direction and normal mode, every synchronized falling edge on either wire raises `activity_o` for one clock.
- R10: In send direction, or in any mode other than normal, `rx_state_o` reads 0 and `collision_o` and `activity_o` stay low, whatever the wire levels.
- R11: While `rst_n` is low, `link_pull_o` is 2'b00, `rx_state_o` is 0 and both pulses are low. The synchronizer history resets to the high (released) level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drive_dir_i | input | 1 | 1 = send local state, 0 = receive from wires |
| op_mode_i | input | 3 | Operating mode, 0 = normal |
| bus_state_i | input | 2 | Local bus state to send |
| link_lvl_i | input | 2 | Sampled wire levels, bit n = wire n |
| link_pull_o | output | 2 | Open-drain enable per wire, 1 = pull low |
| rx_state_o | output | 2 | Decoded bus state from the wires |
| collision_o | output | 1 | One-clock pulse on entry to both-wires-low |
| activity_o | output | 1 | One-clock pulse per falling edge |

## Verification
The send path is driven with every bus state code in normal mode and in each non-normal mode. This separates the wire map from the mode gate and from the direction gate. The receive path is driven with single-wire drops on each wire, a staggered drop where the second wire falls while the first is already low, a simultaneous drop of both wires, and a release of one wire from the both-low state. Together these separate edge-driven decoding from level-driven decoding, show which wire wins a collision, and show whether the state is held when there is no edge. Wire toggles applied while the port sends or sleeps check that decoding is suppressed. Every receive check is sampled at the synchronizer latency, so an extra or missing flop stage is caught.

// File: rtl/ilink_pkg.sv
package ilink_pkg;

   typedef enum logic [1:0] {
      BS_IDLE = 2'd0,
      BS_LOW  = 2'd1,
      BS_HIGH = 2'd2,
      BS_RSVD = 2'd3
   } bus_sym_e;

   typedef enum logic [2:0] {
      OM_NORMAL   = 3'd0,
      OM_STANDBY  = 3'd1,
      OM_SLEEP    = 3'd2,
      OM_POWEROFF = 3'd3,
      OM_RESET    = 3'd4
   } op_mode_e;

   localparam int unsigned WIRES = 2;

endpackage

// File: rtl/ilink_sync.sv
module ilink_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2,
   parameter logic        INIT   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   localparam logic [WIDTH-1:0] INIT_VEC = {WIDTH{INIT}};

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("ilink_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   genvar st;
   generate
      for (st = 0; st < STAGES; st++) begin : g_stage
         if (st == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= INIT_VEC;
               else        chain[0] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[st] <= INIT_VEC;
               else        chain[st] <= chain[st-1];
            end
         end
      end
   endgenerate

   assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/ilink_encoder.sv
module ilink_encoder
   import ilink_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_en_i,
   input  bus_sym_e         sym_i,
   output logic [WIRES-1:0] pull_o
);

   logic [WIRES-1:0] pull_next;

   always_comb begin
      pull_next = '0;
      if (tx_en_i) begin
         unique case (sym_i)
            BS_LOW:  pull_next = 2'b01;
            BS_HIGH: pull_next = 2'b10;
            default: pull_next = 2'b00;
         endcase
      end
   end

   generate
      if (REG_OUT) begin : g_reg
         logic [WIRES-1:0] pull_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pull_q <= '0;
            else        pull_q <= pull_next;
         end
         assign pull_o = pull_q;

         // R1: a low symbol pulls wire 0 only
         p_low_sym_wire0_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_en_i && sym_i == BS_LOW) |=> (pull_o == 2'b01));
         // R2: a high symbol pulls wire 1 only
         p_high_sym_wire1_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_en_i && sym_i == BS_HIGH) |=> (pull_o == 2'b10));
         // R4: gated sender releases both wires
         p_release_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!tx_en_i) |=> (pull_o == 2'b00));
      end else begin : g_comb
         assign pull_o = pull_next;
         always_comb begin
            // R4: no wire pulled while gated
            p_release_comb_r4: assert (tx_en_i || pull_o == 2'b00);
         end
      end
   endgenerate

endmodule

// File: rtl/ilink_decoder.sv
module ilink_decoder
   import ilink_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en_i,
   input  logic [WIRES-1:0] lvl_i,
   output bus_sym_e         sym_o,
   output logic             coll_o,
   output logic             act_o
);

   logic [WIRES-1:0] lvl_prev;
   logic [WIRES-1:0] fall;
   logic             both_low, both_low_prev, both_high;
   bus_sym_e         sym_q, sym_next;
   logic             coll_q, act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_prev <= '1;
      else        lvl_prev <= lvl_i;
   end

   genvar w;
   generate
      for (w = 0; w < WIRES; w++) begin : g_edge
         assign fall[w] = lvl_prev[w] & ~lvl_i[w];
      end
   endgenerate

   assign both_low      = ~|lvl_i;
   assign both_low_prev = ~|lvl_prev;
   assign both_high     = &lvl_i;

   always_comb begin
      sym_next = sym_q;
      if (!rx_en_i)      sym_next = BS_IDLE;
      else if (both_low) sym_next = BS_LOW;
      else if (fall[0])  sym_next = BS_LOW;
      else if (fall[1])  sym_next = BS_HIGH;
      else if (both_high) sym_next = BS_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sym_q  <= BS_IDLE;
         coll_q <= 1'b0;
         act_q  <= 1'b0;
      end else begin
         sym_q  <= sym_next;
         coll_q <= rx_en_i & both_low & ~both_low_prev;
         act_q  <= rx_en_i & (|fall);
      end
   end

   assign sym_o  = sym_q;
   assign coll_o = coll_q;
   assign act_o  = act_q;

   // R8: collision is a single-clock pulse
   p_coll_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      coll_o |=> !coll_o);
   // R8: a collision reports the low symbol
   p_coll_low_sym_r8: assert property (@(posedge clk) disable iff (!rst_n)
      coll_o |-> (sym_o == BS_LOW));
   // R10: disabled receiver stays quiet
   p_rx_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en_i) |=> (sym_o == BS_IDLE && !coll_o && !act_o));
   // R9: activity needs a receiver enabled on the previous clock
   p_act_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_o) |-> $past(rx_en_i));

endmodule

// File: rtl/ilink_port.sv
module ilink_port
   import ilink_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          REG_OUT     = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       drive_dir_i,
   input  logic [2:0] op_mode_i,
   input  logic [1:0] bus_state_i,
   input  logic [1:0] link_lvl_i,
   output logic [1:0] link_pull_o,
   output logic [1:0] rx_state_o,
   output logic       collision_o,
   output logic       activity_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ilink_port: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             mode_normal;
   logic             tx_en, rx_en;
   logic [WIRES-1:0] lvl_sync;
   bus_sym_e         rx_sym;

   assign mode_normal = (op_mode_i == OM_NORMAL);
   assign tx_en       = drive_dir_i & mode_normal;
   assign rx_en       = ~drive_dir_i & mode_normal;

   ilink_encoder #(
      .REG_OUT (REG_OUT)
   ) u_enc (
      .clk     (clk),
      .rst_n   (rst_n),
      .tx_en_i (tx_en),
      .sym_i   (bus_sym_e'(bus_state_i)),
      .pull_o  (link_pull_o)
   );

   ilink_sync #(
      .WIDTH  (WIRES),
      .STAGES (SYNC_STAGES),
      .INIT   (1'b1)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (link_lvl_i),
      .sync_o  (lvl_sync)
   );

   ilink_decoder u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .rx_en_i (rx_en),
      .lvl_i   (lvl_sync),
      .sym_o   (rx_sym),
      .coll_o  (collision_o),
      .act_o   (activity_o)
   );

   assign rx_state_o = rx_sym;

   // R1: the sender never pulls both wires at once
   always_comb begin
      p_one_wire_max_r1: assert (!(link_pull_o[0] && link_pull_o[1]));
   end

endmodule

// File: tb/test_ilink_port.sv
`timescale 1ns/1ps
module test_ilink_port;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       drive_dir_i = 1'b1;
   logic [2:0] op_mode_i = 3'd0;
   logic [1:0] bus_state_i = 2'd0;
   logic [1:0] link_lvl_i = 2'b11;
   logic [1:0] link_pull_o;
   logic [1:0] rx_state_o;
   logic       collision_o;
   logic       activity_o;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   typedef struct {
      int         at;
      int         kind;
      logic [1:0] val;
      string      req;
   } exp_t;
   exp_t sb_q[$];

   ilink_port i_ilink_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .drive_dir_i (drive_dir_i),
      .op_mode_i   (op_mode_i),
      .bus_state_i (bus_state_i),
      .link_lvl_i  (link_lvl_i),
      .link_pull_o (link_pull_o),
      .rx_state_o  (rx_state_o),
      .collision_o (collision_o),
      .activity_o  (activity_o)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // kinds: 0 pull, 1 rx state, 2 collision, 3 activity
   task automatic push(int dly, int kind, logic [1:0] v, string req);
      exp_t e;
      e.at = cyc + dly; e.kind = kind; e.val = v; e.req = req;
      sb_q.push_back(e);
   endtask

   task automatic rx_exp(int dly, logic [1:0] st, logic c, logic a, string req);
      push(dly, 1, st, req);
      push(dly, 2, {1'b0, c}, req);
      push(dly, 3, {1'b0, a}, req);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: pop due items and compare
   always @(negedge clk) begin
      for (int i = sb_q.size() - 1; i >= 0; i--) begin
         if (sb_q[i].at == cyc) begin
            logic [1:0] act;
            case (sb_q[i].kind)
               0:       act = link_pull_o;
               1:       act = rx_state_o;
               2:       act = {1'b0, collision_o};
               default: act = {1'b0, activity_o};
            endcase
            n_chk++;
            if (act !== sb_q[i].val) begin
               n_fail++;
               $display("FAIL %s kind=%0d cycle=%0d actual=%b expected=%b",
                        sb_q[i].req, sb_q[i].kind, cyc, act, sb_q[i].val);
            end
            sb_q.delete(i);
         end
      end
   end

   initial begin
      idle(4);
      rst_n = 1'b1;
      // R11: reset state
      push(0 + 1, 0, 2'b00, "R11");
      rx_exp(1, 2'd0, 1'b0, 1'b0, "R11");
      idle(2);

      // send direction, normal mode
      bus_state_i = 2'd1; push(1, 0, 2'b01, "R1"); idle(2);
      bus_state_i = 2'd2; push(1, 0, 2'b10, "R2"); idle(2);
      bus_state_i = 2'd0; push(1, 0, 2'b00, "R3"); idle(2);
      bus_state_i = 2'd3; push(1, 0, 2'b00, "R3"); idle(2);
      bus_state_i = 2'd1; push(1, 0, 2'b01, "R1"); idle(2);
      for (int m = 1; m < 6; m++) begin
         op_mode_i = 3'(m); push(1, 0, 2'b00, "R4"); idle(2);
      end
      op_mode_i = 3'd0; push(1, 0, 2'b01, "R1"); idle(2);
      drive_dir_i = 1'b0; push(1, 0, 2'b00, "R4"); idle(2);
      drive_dir_i = 1'b1; bus_state_i = 2'd0; idle(2);

      // R10: wires toggled while sending are not decoded
      link_lvl_i = 2'b10; rx_exp(3, 2'd0, 1'b0, 1'b0, "R10"); idle(5);
      link_lvl_i = 2'b11; idle(5);

      // receive direction, normal mode
      drive_dir_i = 1'b0; idle(4);
      link_lvl_i = 2'b10;
      rx_exp(2, 2'd0, 1'b0, 1'b0, "R5");
      rx_exp(3, 2'd1, 1'b0, 1'b1, "R6");
      rx_exp(4, 2'd1, 1'b0, 1'b0, "R9");
      idle(6);
      link_lvl_i = 2'b11; rx_exp(3, 2'd0, 1'b0, 1'b0, "R7"); idle(6);
      link_lvl_i = 2'b01; rx_exp(3, 2'd2, 1'b0, 1'b1, "R6"); idle(6);
      // staggered: wire 0 falls while wire 1 already low
      link_lvl_i = 2'b00;
      rx_exp(3, 2'd1, 1'b1, 1'b1, "R8");
      rx_exp(4, 2'd1, 1'b0, 1'b0, "R8");
      idle(6);
      // release wire 0, wire 1 still low: no edge, state held
      link_lvl_i = 2'b01; rx_exp(3, 2'd1, 1'b0, 1'b0, "R6"); idle(6);
      link_lvl_i = 2'b11; rx_exp(3, 2'd0, 1'b0, 1'b0, "R7"); idle(6);
      // simultaneous drop of both wires
      link_lvl_i = 2'b00;
      rx_exp(3, 2'd1, 1'b1, 1'b1, "R8");
      rx_exp(5, 2'd1, 1'b0, 1'b0, "R8");
      idle(6);
      link_lvl_i = 2'b11; idle(6);

      // R10: non-normal mode suppresses decoding
      op_mode_i = 3'd1; link_lvl_i = 2'b10;
      rx_exp(3, 2'd0, 1'b0, 1'b0, "R10"); idle(6);
      link_lvl_i = 2'b00; rx_exp(3, 2'd0, 1'b0, 1'b0, "R10"); idle(6);
      link_lvl_i = 2'b11; idle(5);
      op_mode_i = 3'd0; idle(3);

      idle(4);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule